// File: doc/BRIEF.md
# Guarded Clock Divider Control

This block turns a free-running master clock into a periodic enable pulse whose rate is a power-of-two fraction of the master rate. Logic that should run slower qualifies its registers with the pulse instead of using a second clock. The ratio sits in a small control register on a plain write bus and can always be read back.

The ratio cannot be changed by a single stray write. Software first writes a byte with only the top bit set, which arms a short unlock window. The ratio write must then follow within four master cycles and must carry a zero in the top bit. An unused window closes by itself. The ratio loaded at reset comes from a strap input, so a board whose source clock is too fast can start at one eighth speed.

Top module: `clk_prescale_guard`

## Requirements
- R1: The read value has the unlock flag in bit 7, the ratio code in bits 3..0 and zeros in bits 6..4.
- R2: The unlock flag sets only on a write of exactly 0x80. Any other write made while the flag is clear leaves the flag clear and the code unchanged.
- R3: A set flag stays set for four cycles. A ratio write is accepted on the fourth edge after arming and refused on the fifth.
- R4: Writing 0x80 again while the flag is set neither clears the flag nor lengthens its window.
- R5: The code changes only through a write that has bit 7 at zero while the flag is set. That write also clears the flag.
- R6: Codes 0 to 8 give a pulse period of 1, 2, 4, 8, 16, 32, 64, 128 and 256 master cycles.
- R7: Codes 9 to 15 are stored and read back unchanged, and they give a period of 1.
- R8: Reset loads code 0 when the strap is low and code 3 when it is high. Any code can be written afterwards.
- R9: A new ratio starts only after the pulse that ends the current period, so no period is cut short.
- R10: When the period is longer than one cycle, the pulse is exactly one master cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_div8 | input | 1 | Selects the reset ratio: high gives divide by 8 |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control register read value |
| tick | output | 1 | Divided enable pulse |

## Verification
The hardest case to reach is the edge of the unlock window. The ratio write has to land on the fourth or the fifth edge after arming, and sometimes after a second 0x80 write inside the window. The bench drives writes on falling edges and inserts counted idle cycles, so each write falls on a known edge. The ratio handover is checked the same way. The bench first lines up on a pulse of a 256-cycle period, then changes the ratio partway through that period and counts the cycles to the next pulse.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
   localparam int CPG_REG_W    = 8;
   localparam int CPG_SEL_W    = 4;
   localparam int CPG_ARM_BIT  = 7;
   localparam int CPG_WINDOW   = 4;
   localparam int CPG_MAX_CODE = 8;
   localparam int CPG_STRAP    = 3;
endpackage

// File: rtl/cpg_unlock.sv
module cpg_unlock #(
   parameter int REG_W   = 8,
   parameter int SEL_W   = 4,
   parameter int ARM_BIT = 7,
   parameter int WINDOW  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] rst_code,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic             armed_o,
   output logic [SEL_W-1:0] sel_o
);
   localparam int AGE_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
   localparam int RUN_W = $clog2(WINDOW + 2);
   localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(WINDOW - 1);
   localparam logic [REG_W-1:0] ARM_PAT  = REG_W'(1) << ARM_BIT;
   localparam logic [RUN_W-1:0] RUN_MAX  = '1;

   if (ARM_BIT >= REG_W || ARM_BIT < SEL_W) begin : g_bad_bit
      $error("arm bit must sit above the select field inside the register");
   end
   if (WINDOW < 2) begin : g_bad_win
      $error("unlock window must be at least two cycles");
   end

   logic             armed;
   logic [AGE_W-1:0] age;
   logic [SEL_W-1:0] sel;
   logic             arm_wr, sel_wr;

   assign arm_wr = wr_en && (wr_data == ARM_PAT);
   assign sel_wr = wr_en && !wr_data[ARM_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         age   <= '0;
         sel   <= rst_code;
      end else if (armed) begin
         if (sel_wr) begin
            sel   <= wr_data[SEL_W-1:0];
            armed <= 1'b0;
         end else if (age == AGE_LAST) begin
            armed <= 1'b0;
         end else begin
            age <= age + 1'b1;
         end
      end else if (arm_wr) begin
         armed <= 1'b1;
         age   <= '0;
      end
   end

   assign armed_o = armed;
   assign sel_o   = sel;

   // Window check: counts the consecutive cycles in which the flag has been set.
   logic [RUN_W-1:0] armed_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              armed_run <= '0;
      else if (!armed)         armed_run <= '0;
      else if (armed_run != RUN_MAX) armed_run <= armed_run + 1'b1;
   end

   // R2
   arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(wr_en && wr_data == ARM_PAT));
   // R3
   arm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (armed_run < RUN_W'(WINDOW)));
   // R4
   rearm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_en && wr_data[ARM_BIT] && armed_run < RUN_W'(WINDOW - 1)) |=> armed);
   // R5
   sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel) |-> $past(armed && wr_en && !wr_data[ARM_BIT]));
   // R5
   sel_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_en && !wr_data[ARM_BIT]) |=> !armed);
endmodule

// File: rtl/cpg_decode.sv
module cpg_decode #(
   parameter int SEL_W    = 4,
   parameter int MAX_CODE = 8,
   parameter int SH_W     = $clog2(MAX_CODE + 1)
) (
   input  logic [SEL_W-1:0] code,
   output logic [SH_W-1:0]  shift_o
);
   if (MAX_CODE >= (1 << SEL_W)) begin : g_bad_code
      $error("largest code does not fit the select field");
   end

   logic [MAX_CODE:0] hit;

   for (genvar g = 0; g <= MAX_CODE; g++) begin : g_hit
      assign hit[g] = (code == SEL_W'(g));
   end

   always_comb begin
      shift_o = '0;
      for (int i = 0; i <= MAX_CODE; i++) begin
         if (hit[i]) shift_o = shift_o | SH_W'(i);
      end
      // R7
      decode_onehot_chk: assert ($onehot0(hit));
   end
endmodule

// File: rtl/cpg_divider.sv
module cpg_divider #(
   parameter int MAX_CODE = 8,
   parameter int SH_W     = $clog2(MAX_CODE + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SH_W-1:0] rst_shift,
   input  logic [SH_W-1:0] new_shift,
   output logic            tick
);
   localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

   if (MAX_CODE < 1) begin : g_bad_max
      $error("divider needs at least one ratio above one");
   end

   logic [SH_W-1:0]  shift_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] limit;

   assign span  = (CNT_W + 1)'(1) << shift_q;
   assign limit = CNT_W'(span - (CNT_W + 1)'(1));
   assign tick  = (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         shift_q <= rst_shift;
      end else if (tick) begin
         cnt     <= '0;
         shift_q <= new_shift;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9
   ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shift_q) |-> $past(tick));
   // R10
   tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && new_shift != '0) |=> !tick);
endmodule

// File: rtl/clk_prescale_guard.sv
module clk_prescale_guard
   import cpg_pkg::*;
#(
   parameter int REG_W      = CPG_REG_W,
   parameter int SEL_W      = CPG_SEL_W,
   parameter int ARM_BIT    = CPG_ARM_BIT,
   parameter int WINDOW     = CPG_WINDOW,
   parameter int MAX_CODE   = CPG_MAX_CODE,
   parameter int STRAP_CODE = CPG_STRAP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_div8,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             tick
);
   localparam int SH_W = $clog2(MAX_CODE + 1);

   if (STRAP_CODE > MAX_CODE) begin : g_bad_strap
      $error("strap code must be a valid ratio code");
   end

   logic [SEL_W-1:0] rst_code, sel;
   logic [SH_W-1:0]  rst_shift, new_shift;
   logic             armed;

   assign rst_code = strap_div8 ? SEL_W'(STRAP_CODE) : '0;

   cpg_unlock #(.REG_W(REG_W), .SEL_W(SEL_W), .ARM_BIT(ARM_BIT), .WINDOW(WINDOW)) u_unlock (
      .clk(clk), .rst_n(rst_n), .rst_code(rst_code), .wr_en(wr_en), .wr_data(wr_data),
      .armed_o(armed), .sel_o(sel));

   cpg_decode #(.SEL_W(SEL_W), .MAX_CODE(MAX_CODE), .SH_W(SH_W)) u_dec_run (
      .code(sel), .shift_o(new_shift));

   cpg_decode #(.SEL_W(SEL_W), .MAX_CODE(MAX_CODE), .SH_W(SH_W)) u_dec_rst (
      .code(rst_code), .shift_o(rst_shift));

   cpg_divider #(.MAX_CODE(MAX_CODE), .SH_W(SH_W)) u_div (
      .clk(clk), .rst_n(rst_n), .rst_shift(rst_shift), .new_shift(new_shift), .tick(tick));

   always_comb begin
      rd_data               = '0;
      rd_data[ARM_BIT]      = armed;
      rd_data[SEL_W-1:0]    = sel;
   end

   // R1
   rd_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[ARM_BIT-1:SEL_W] == '0);
endmodule

// File: tb/sim_clk_prescale_guard.sv
module sim_clk_prescale_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_div8 = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       tick;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   clk_prescale_guard u0 (
      .clk(clk), .rst_n(rst_n), .strap_div8(strap_div8),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .tick(tick));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   // Called at a falling edge; the write lands on the next rising edge.
   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic strap);
      rst_n = 1'b0; strap_div8 = strap;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic measure(output int n);
      int guard = 0;
      while (!tick && guard < 1000) begin @(negedge clk); guard++; end
      n = 0;
      do begin @(negedge clk); n++; end while (!tick && n < 1000);
   endtask

   task automatic set_code(input logic [7:0] c);
      wr(8'h80);
      wr(c);
   endtask

   task automatic t_reset;
      int p;
      do_reset(1'b0);
      chk("R8 reset code strap low", rd_data, 8'h00);
      measure(p);
      chk("R8 period strap low", p, 1);
      do_reset(1'b1);
      chk("R8 reset code strap high", rd_data, 8'h03);
      chk("R1 reset pad bits", rd_data[6:4], 0);
      measure(p);
      chk("R8 period strap high", p, 8);
   endtask

   task automatic t_arm_guard;
      wr(8'h81); chk("R2 0x81 does not arm", rd_data, 8'h03);
      wr(8'hC0); chk("R2 0xC0 does not arm", rd_data, 8'h03);
      wr(8'h05); chk("R5 unarmed code write ignored", rd_data, 8'h03);
      wr(8'h80); chk("R2 0x80 arms, R1 layout", rd_data, 8'h83);
      wr(8'h02); chk("R5 armed code write taken and flag cleared", rd_data, 8'h02);
   endtask

   task automatic t_window;
      wr(8'h80); idle(3);
      chk("R3 still armed before fourth edge", rd_data, 8'h84 - 8'h02);
      wr(8'h04); chk("R3 write on fourth edge accepted", rd_data, 8'h04);
      wr(8'h80); idle(4);
      chk("R3 flag expired after four cycles", rd_data, 8'h04);
      wr(8'h06); chk("R3 write on fifth edge refused", rd_data, 8'h04);
   endtask

   task automatic t_rearm;
      wr(8'h80); wr(8'h80);
      chk("R4 re-write keeps flag", rd_data, 8'h84);
      idle(2);
      wr(8'h01); chk("R4 window not cleared by re-write", rd_data, 8'h01);
      wr(8'h80); idle(1); wr(8'h80); idle(2);
      chk("R4 window not extended by re-write", rd_data, 8'h01);
      wr(8'h07); chk("R4 write after original window refused", rd_data, 8'h01);
   endtask

   task automatic t_ratios;
      int p;
      for (int c = 0; c <= 8; c++) begin
         set_code(8'(c));
         chk("R6 code readback", rd_data, c);
         measure(p); measure(p);
         chk($sformatf("R6 period code %0d", c), p, 1 << c);
         if (c > 0) begin
            @(negedge clk);
            chk($sformatf("R10 pulse width code %0d", c), tick, 0);
         end
      end
   endtask

   task automatic t_reserved;
      int p;
      set_code(8'h0B);
      chk("R7 reserved code stored", rd_data, 8'h0B);
      measure(p); measure(p);
      chk("R7 reserved 0xB divides by 1", p, 1);
      set_code(8'h0F);
      chk("R7 reserved code 0xF stored", rd_data, 8'h0F);
      measure(p); measure(p);
      chk("R7 reserved 0xF divides by 1", p, 1);
   endtask

   task automatic t_boundary;
      int p;
      int n;
      set_code(8'h08);
      measure(p); measure(p);
      n = 0;
      wr(8'h80); n++;
      wr(8'h01); n++;
      while (!tick && n < 1000) begin @(negedge clk); n++; end
      chk("R9 old period completes", n, 256);
      measure(p);
      chk("R9 new period after boundary", p, 2);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_arm_guard();
      t_window();
      t_rearm();
      t_ratios();
      t_reserved();
      t_boundary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule